// File: doc/BRIEF.md
# Interrupt notify-acknowledge controller

This block gathers interrupt requests from up to 256 peripheral lines and hands them to a processor one at a time. A request is the rising edge of a line. The block latches each new request as pending, then presents the lowest-numbered pending line. To present it, the block pulls an active-low notify output low and puts the line index and the line's target processor ID on dedicated outputs. Firmware raises the acknowledge input to retire the request. The same action serves as the start-up step that puts the outputs into their idle state.

Firmware programs per-line routing through a memory-mapped table with one 32-bit word per line. The low byte holds the target processor ID, and the next bit masks the line. The table starts at a configurable base address, by default 0x0100_0000, and has a 4-byte stride. Accesses use separate read and write strobes.

Top module: `irq_notify_ctrl`

## Requirements
- R1: While reset is applied and afterwards, until a request is presented: notify_no is 1, line_o is 0 and proc_id_o is 0. Every table word reads as 0.
- R2: The controller may be idle with nothing pending. If line n is first sampled high at clock edge k, notify_no stays 1 after edge k, then goes 0 with line_o = n after edge k+1. It holds that value until acknowledged.
- R3: At every clock edge where ack_i is 1, notify_no becomes 1 and line_o and proc_id_o become 0. No request is presented while ack_i stays 1.
- R4: A request that arrives while another is being presented is kept pending. At the first edge where ack_i is 0 and nothing is being presented, the lowest-numbered pending line is presented.
- R5: Only a 0-to-1 transition of a line creates a request. A line held high creates no further request.
- R6: When bit 8 of a line's table word is 1, rising edges on that line are dropped. They are not latched, so clearing the mask later presents nothing.
- R7: While notify_no is 0, proc_id_o equals bits 7:0 of the presented line's table word. Otherwise it is 0.
- R8: Writing wdata to base + 4*n with mmio_we_i high stores wdata[7:0] as the processor ID and wdata[8] as the mask of entry n. A read strobe at edge k places the word on mmio_rdata_o after edge k, and bits 31:9 read as 0. mmio_re_i and mmio_we_i are never high together.
- R9: An address below the base, at or beyond base + 1024, or not 4-byte aligned leaves the table unchanged on writes and returns 0 on reads.
- R10: When several unmasked lines rise at the same edge, they are presented in ascending line order, one per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 256 | Peripheral request lines, one bit per line |
| ack_i | input | 1 | Acknowledge / initialise, active high |
| mmio_addr_i | input | 32 | Byte address of a table access |
| mmio_re_i | input | 1 | Read strobe |
| mmio_we_i | input | 1 | Write strobe |
| mmio_wdata_i | input | 32 | Write data |
| mmio_rdata_o | output | 32 | Read data, registered |
| notify_no | output | 1 | Request presented, active low |
| line_o | output | 8 | Index of the presented line, 0 when idle |
| proc_id_o | output | 8 | Target processor ID of the presented line, 0 when idle |

## Verification
The assertions take for granted that the read and write strobes are never high in the same cycle. They also assume the request lines and acknowledge change only between clock edges. The stimulus drives every input on the falling clock edge and issues each table access as a single-strobe cycle, so both conditions always hold. Request pulses and acknowledge pulses are held for a parameterised number of cycles that stand in for the millisecond widths. Because detection is edge-based, these widths only need to exceed one clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PID_W = 8;

  typedef struct packed {
    logic             masked;
    logic [PID_W-1:0] pid;
  } route_t;

  localparam int unsigned ROUTE_W = $bits(route_t);
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 256,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int unsigned N     = 256,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_i,
  input  logic [N-1:0]     mask_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [N-1:0]     pend_o
);
  logic [N-1:0] irq_q, pend_q, pend_d, rise;

  assign rise = irq_i & ~irq_q;

  always_comb begin
    pend_d = (pend_q | rise) & ~mask_i;
    if (clr_i) pend_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R5: a held-high line never re-arms its pending bit once cleared
  assert_no_retrig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && irq_i[clr_idx_i] && irq_q[clr_idx_i] |=> !pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_pkg::*;
#(
  parameter int unsigned N         = 256,
  parameter int unsigned IDX_W     = $clog2(N),
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N-1:0]      mask_o,
  input  logic [IDX_W-1:0]  look_idx_i,
  output logic [PID_W-1:0]  look_id_o
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(N * 4);

  route_t            tbl_q [N];
  logic [ADDR_W-1:0] off;
  logic              in_win;
  logic [IDX_W-1:0]  idx;
  route_t            wr_ent;

  assign off    = addr_i - BASE_ADDR;
  assign in_win = (addr_i >= BASE_ADDR) && (off < WIN_BYTES) && (off[1:0] == 2'b00);
  assign idx    = off[IDX_W+1:2];
  assign wr_ent = '{masked: wdata_i[PID_W], pid: wdata_i[PID_W-1:0]};

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tbl_q[g] <= '0;
      else if (we_i && in_win && idx == IDX_W'(g)) tbl_q[g] <= wr_ent;
    end
    assign mask_o[g] = tbl_q[g].masked;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= in_win ? {{(DATA_W-ROUTE_W){1'b0}}, tbl_q[idx]} : '0;
  end

  assign look_id_o = tbl_q[look_idx_i].pid;

  // R8: strobes are mutually exclusive
  assert_rw_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && we_i));
  // R8: reserved bits never appear on a read
  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rdata_o[DATA_W-1:ROUTE_W] == '0);
  // R9: reads outside the window return zero
  assert_oow_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !in_win |=> rdata_o == '0);
endmodule

// File: rtl/irq_notify_ctrl.sv
module irq_notify_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N         = 256,
  parameter int unsigned IDX_W     = $clog2(N),
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      irq_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] mmio_addr_i,
  input  logic              mmio_re_i,
  input  logic              mmio_we_i,
  input  logic [DATA_W-1:0] mmio_wdata_i,
  output logic [DATA_W-1:0] mmio_rdata_o,
  output logic              notify_no,
  output logic [IDX_W-1:0]  line_o,
  output logic [PID_W-1:0]  proc_id_o
);
  logic [N-1:0]     mask, pend;
  logic             pick_vld, present, busy_q;
  logic [IDX_W-1:0] pick_idx, line_q;
  logic [PID_W-1:0] look_id;

  irq_route_table #(
    .N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (mmio_addr_i),
    .re_i       (mmio_re_i),
    .we_i       (mmio_we_i),
    .wdata_i    (mmio_wdata_i),
    .rdata_o    (mmio_rdata_o),
    .mask_o     (mask),
    .look_idx_i (line_q),
    .look_id_o  (look_id)
  );

  irq_edge_capture #(.N(N), .IDX_W(IDX_W)) i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mask_i    (mask),
    .clr_i     (present),
    .clr_idx_i (pick_idx),
    .pend_o    (pend)
  );

  irq_prio_pick #(.N(N), .IDX_W(IDX_W)) i_pick (
    .req_i   (pend),
    .valid_o (pick_vld),
    .idx_o   (pick_idx)
  );

  assign present = !busy_q && !ack_i && pick_vld;

  // ack dominates: it clears and blocks presentation in the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= '0;
    end else if (ack_i) begin
      busy_q <= 1'b0;
      line_q <= '0;
    end else if (present) begin
      busy_q <= 1'b1;
      line_q <= pick_idx;
    end
  end

  assign notify_no = ~busy_q;
  assign line_o    = line_q;
  assign proc_id_o = busy_q ? look_id : '0;

  // R3: acknowledge always returns the outputs to idle
  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> notify_no && line_o == '0 && proc_id_o == '0);
  // R7: idle outputs carry no ID
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_no |-> proc_id_o == '0 && line_o == '0);
  // R2: a presented line is held until acknowledged
  assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !notify_no && !ack_i |=> !notify_no && $stable(line_o));
  // R4: notify only falls with something pending and no acknowledge
  assert_fall_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(notify_no) |-> $past(pend != '0) && !$past(ack_i));
endmodule

// File: tb/test_irq_notify_ctrl.sv
`timescale 1ns/1ps
module test_irq_notify_ctrl;
  localparam int N = 256;
  localparam logic [31:0] BASE = 32'h0100_0000;
  localparam int ACK_CYCLES = 4;
  localparam int REQ_CYCLES = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic ack = 1'b0, re = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic notify_n;
  logic [7:0] line, pid;

  always #10 clk = ~clk;

  irq_notify_ctrl i_irq_notify_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_i(ack),
    .mmio_addr_i(addr), .mmio_re_i(re), .mmio_we_i(we), .mmio_wdata_i(wdata),
    .mmio_rdata_o(rdata), .notify_no(notify_n), .line_o(line), .proc_id_o(pid)
  );

  typedef struct {
    int          req;
    bit          is_rd;
    logic        notify;
    logic [7:0]  line;
    logic [7:0]  pid;
    logic [31:0] rdata;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int total = 0, bad = 0;

  // monitor: pops expected items when the driver signals a sample point
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (e.is_rd) begin
        if (rdata !== e.rdata) begin
          bad++;
          $display("FAIL R%0d rdata act=%h exp=%h", e.req, rdata, e.rdata);
        end
      end else if (notify_n !== e.notify || line !== e.line || pid !== e.pid) begin
        bad++;
        $display("FAIL R%0d n/line/pid act=%b/%0d/%h exp=%b/%0d/%h",
                 e.req, notify_n, line, pid, e.notify, e.line, e.pid);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic expect_out(int r, logic n, logic [7:0] l, logic [7:0] p);
    exp_t e;
    e = '{req: r, is_rd: 1'b0, notify: n, line: l, pid: p, rdata: '0};
    q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic expect_rd(int r, logic [31:0] a, logic [31:0] d);
    exp_t e;
    addr = a; re = 1'b1;
    tick();
    re = 1'b0;
    e = '{req: r, is_rd: 1'b1, notify: 1'b0, line: '0, pid: '0, rdata: d};
    q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    expect_out(3, 1'b1, 8'd0, 8'h00);  // R3 cleared at first edge
    tick(ACK_CYCLES - 1);
    expect_out(3, 1'b1, 8'd0, 8'h00);  // R3 nothing presented while held
    ack = 1'b0;
    tick();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    expect_out(1, 1'b1, 8'd0, 8'h00);     // R1 during reset
    rst_n = 1'b1;
    tick();
    expect_out(1, 1'b1, 8'd0, 8'h00);     // R1 after reset
    expect_rd(1, BASE + 32'd20, 32'h0);   // R1 table cleared

    // R8 programming and readback, reserved bits dropped
    wr(BASE + 32'd12, 32'h0000_00A5);
    wr(BASE + 32'd28, 32'hFFFF_FF42);
    expect_rd(8, BASE + 32'd28, 32'h0000_0142);
    expect_rd(8, BASE + 32'd12, 32'h0000_00A5);
    wr(BASE + 32'd400, 32'h0000_003C);    // entry 100

    // R2 latency and R7 ID output
    irq[3] = 1'b1;
    tick();
    expect_out(2, 1'b1, 8'd0, 8'h00);     // R2 not yet after first edge
    tick();
    expect_out(2, 0, 8'd3, 8'hA5);        // R2, R7
    // R4 new requests while busy; R6 masked line 7
    irq[4] = 1'b1; irq[9] = 1'b1; irq[7] = 1'b1;
    tick(REQ_CYCLES);
    expect_out(4, 0, 8'd3, 8'hA5);        // R4 still holding line 3
    irq[4] = 1'b0; irq[9] = 1'b0; irq[7] = 1'b0;
    do_ack();
    expect_out(4, 0, 8'd4, 8'h00);        // R4 lowest pending first
    do_ack();
    expect_out(4, 0, 8'd9, 8'h00);        // R4 next pending
    do_ack();
    expect_out(5, 1'b1, 8'd0, 8'h00);     // R5 held line 3, R6 masked 7: nothing
    tick(2);
    expect_out(5, 1'b1, 8'd0, 8'h00);     // R5 still idle
    wr(BASE + 32'd28, 32'h0000_0042);     // R6 unmask line 7
    tick(3);
    expect_out(6, 1'b1, 8'd0, 8'h00);     // R6 dropped request not latched
    irq[3] = 1'b0;
    tick();

    // R10 simultaneous rises
    irq[200] = 1'b1; irq[12] = 1'b1; irq[100] = 1'b1;
    tick(2);
    expect_out(10, 0, 8'd12, 8'h00);      // R10
    tick(REQ_CYCLES);
    irq[200] = 1'b0; irq[12] = 1'b0; irq[100] = 1'b0;
    do_ack();
    expect_out(10, 0, 8'd100, 8'h3C);     // R10, R7
    do_ack();
    expect_out(10, 0, 8'd200, 8'h00);     // R10
    do_ack();
    expect_out(3, 1'b1, 8'd0, 8'h00);     // R3 all retired

    // R9 out-of-window and misaligned accesses
    wr(BASE + 32'd1024, 32'h0000_01FF);   // would alias entry 0
    wr(BASE - 32'd4, 32'h0000_01FF);
    wr(BASE + 32'd13, 32'h0000_0077);     // misaligned into entry 3
    expect_rd(9, BASE, 32'h0);            // R9 entry 0 untouched
    expect_rd(9, BASE + 32'd1020, 32'h0); // R9 entry 255 untouched
    expect_rd(9, BASE + 32'd12, 32'h0000_00A5); // R9 entry 3 untouched
    expect_rd(9, BASE + 32'd1024, 32'h0); // R9 read beyond window
    expect_rd(9, BASE + 32'd29, 32'h0);   // R9 misaligned read
    wr(BASE + 32'd1020, 32'h0000_0011);
    expect_rd(8, BASE + 32'd1020, 32'h0000_0011); // R8 last entry
    // R8 read data latched at the strobe edge
    addr = BASE + 32'd12;
    tick();
    expect_rd(8, BASE + 32'd12, 32'h0000_00A5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule